// File: doc/BRIEF.md
# Paged Module Management Register Target

This block is the management memory of a pluggable link module, reached by a host over a two-wire I2C bus. It answers at two device addresses. One address reaches a 256-byte information block. The other reaches a 256-byte diagnostic block. The upper half of the diagnostic block is paged, and a page-select byte in the lower half chooses which page is visible. Page 0 is general-purpose storage. Page 2 holds the parameters of a wireless link as big-endian multi-byte fields.

The module's own controller has a local write port. Through it the controller stores measured values, including fields that the host may only read. After each bus transaction that wrote parameter bytes, the block reports every stored byte to the local controller as a one-cycle notification. Each notification carries the page and the byte address, so the controller can act on the new setting.

The block works at byte level. The bus lines are sampled with the system clock, and the target pulls the data line low through an open-drain enable. It gives no meaning to the values in any field.

Top module: `xcvr_diag_target`

## Requirements
- R1: The target acknowledges 7-bit device address 50h, which reaches the information block, and 51h, which reaches the diagnostic block. Any other address is not acknowledged. The data line is released whenever the target is idle.
- R2: In a write, the first byte after the device address sets the register pointer. Each later data byte, written or read, moves the pointer on by one, and it wraps from 255 to 0 within the same block. A repeated start keeps the pointer, so a random read is possible.
- R3: The information block and the lower half of the diagnostic block are plain byte storage. They are separate from each other, and their contents are 00h before they are first written.
- R4: Diagnostic byte 127 is the page select. It reads back the value last written and is 00h after reset. Value 00h maps the upper half to page 0 storage, and 02h maps it to the parameter page.
- R5: Parameter page layout, most significant byte at the lowest address:
  - bytes 132–133: centre frequency
  - bytes 134–135: channel width
  - bytes 136–139: TX power
  - bytes 140–143: RX power
  - bytes 144–145: TX bitrate
  - bytes 146–147: RX bitrate
  - byte 148: BER exponent
  - byte 149: MCS index
- R6: Parameter-page bytes outside 132–149 read as 00h, and host writes to them are discarded.
- R7: Host writes to the measured fields (bytes 140–143, 146–147 and 148) are acknowledged but change nothing.
- R8: The local port can write any byte of either block, including the measured fields. When it writes in the same cycle as a pending host byte, the local write goes first and the host byte follows.
- R9: While the page select holds a value other than 00h or 02h, upper-half reads return 00h and upper-half writes are dropped, so page 0 contents survive.
- R10: For each host byte stored on the parameter page, one single-cycle notification (page 02h, byte address) is issued after the stop condition, in ascending address order. Ignored or discarded bytes give no notification.
- R11: After reset the data line is released and no notification is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Pull data line low when 1 |
| loc_we | input | 1 | Local write strobe |
| loc_blk | input | 1 | Local target block: 0 information, 1 diagnostic |
| loc_page | input | 8 | Page used for local writes to the diagnostic upper half |
| loc_addr | input | 8 | Local byte address |
| loc_wdata | input | 8 | Local write data |
| note_vld | output | 1 | One-cycle write notification |
| note_page | output | 8 | Page of the notified byte |
| note_addr | output | 8 | Byte address of the notified byte |

## Verification
The bench runs bursts of one, two, three and four bytes. These include a burst that crosses byte 255, which shows whether the pointer wraps inside its own block or spills over. The same byte offsets are read in the information block, the diagnostic lower half and each page. This separates true storage from aliasing, and a page that is undefined or unimplemented from one that is hidden. Host writes to measured fields and to undefined bytes are mixed with local writes to the same bytes. This shows whether protection applies only to the host, and the notification stream shows which bytes the block took as stored.

// File: rtl/xcvr_diag_pkg.sv
package xcvr_diag_pkg;
  localparam int BYTE_W   = 8;
  localparam int HALF_W   = 7;
  localparam int REGION_W = 3;
  localparam int IDX_W    = REGION_W + HALF_W;
  localparam int NUM_REGIONS = 5;
  localparam int MEM_DEPTH   = NUM_REGIONS << HALF_W;

  localparam logic [REGION_W-1:0] RG_INFO_LO = 3'd0;
  localparam logic [REGION_W-1:0] RG_INFO_HI = 3'd1;
  localparam logic [REGION_W-1:0] RG_DIAG_LO = 3'd2;
  localparam logic [REGION_W-1:0] RG_DIAG_P0 = 3'd3;
  localparam logic [REGION_W-1:0] RG_DIAG_P2 = 3'd4;

  localparam logic [BYTE_W-1:0] PAGE_BASE     = 8'h00;
  localparam logic [BYTE_W-1:0] PAGE_PARAM    = 8'h02;
  localparam logic [BYTE_W-1:0] PAGE_SEL_ADDR = 8'h7F;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } map_t;

  // offset within the upper half: 4..21 are the defined parameter bytes
  function automatic logic p2_defined(input logic [HALF_W-1:0] off);
    return off inside {[7'd4:7'd21]};
  endfunction

  // host may change settings only: frequency, width, TX power, TX bitrate, MCS
  function automatic logic p2_host_writable(input logic [HALF_W-1:0] off);
    return (off inside {[7'd4:7'd11]}) || (off inside {[7'd16:7'd17]}) || (off == 7'd21);
  endfunction

  function automatic map_t map_addr(input logic blk, input logic [BYTE_W-1:0] a,
                                    input logic [BYTE_W-1:0] page, input logic strict);
    map_t m;
    logic [REGION_W-1:0] rg;
    m.hit = 1'b1;
    if (!blk)                 rg = a[BYTE_W-1] ? RG_INFO_HI : RG_INFO_LO;
    else if (!a[BYTE_W-1])    rg = RG_DIAG_LO;
    else if (page == PAGE_BASE) rg = RG_DIAG_P0;
    else begin
      rg    = RG_DIAG_P2;
      m.hit = (page == PAGE_PARAM) && (!strict || p2_defined(a[HALF_W-1:0]));
    end
    m.idx = {rg, a[HALF_W-1:0]};
    return m;
  endfunction
endpackage

// File: rtl/xcvr_i2c_link.sv
module xcvr_i2c_link
  import xcvr_diag_pkg::*;
#(
  parameter logic [6:0] INFO_DEV = 7'h50,
  parameter logic [6:0] DIAG_DEV = 7'h51
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              blk,
  output logic [BYTE_W-1:0] ptr,
  output logic              wr,
  output logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] rdata,
  output logic              stop_p,
  output logic              idle
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_REG, S_WR, S_DACK, S_RD, S_RACK} st_e;
  localparam logic [3:0] BITS = 4'd8;

  st_e               st;
  logic [2:0]        scl_s, sda_s;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sr, tx;
  logic              rd_mode, mack;

  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire start_c  = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  wire stop_c   = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];

  assign idle = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    wr     <= 1'b0;
    stop_p <= 1'b0;
    if (rst) begin
      st <= S_IDLE; sda_oe <= 1'b0; cnt <= '0; sr <= '0; tx <= '0;
      blk <= 1'b0; ptr <= '0; wdata <= '0; rd_mode <= 1'b0; mack <= 1'b0;
    end else begin
      if (wr) ptr <= ptr + 1'b1;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0; stop_p <= 1'b1;
      end else begin
        case (st)
          S_ADDR, S_REG, S_WR: begin
            if (scl_rise) begin
              sr  <= {sr[BYTE_W-2:0], sda_s[1]};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == BITS) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sr[7:1] == INFO_DEV || sr[7:1] == DIAG_DEV) begin
                  blk <= (sr[7:1] == DIAG_DEV); rd_mode <= sr[0];
                  sda_oe <= 1'b1; st <= S_AACK;
                end else st <= S_IDLE;
              end else if (st == S_REG) begin
                ptr <= sr; sda_oe <= 1'b1; st <= S_DACK;
              end else begin
                wr <= 1'b1; wdata <= sr; sda_oe <= 1'b1; st <= S_DACK;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            if (rd_mode) begin
              st <= S_RD; cnt <= '0; sda_oe <= ~rdata[7]; tx <= {rdata[6:0], 1'b0};
            end else begin
              st <= S_REG; sda_oe <= 1'b0;
            end
          end
          S_DACK: if (scl_fall) begin
            sda_oe <= 1'b0; st <= S_WR;
          end
          S_RD: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == BITS) begin
                sda_oe <= 1'b0; st <= S_RACK; ptr <= ptr + 1'b1;
              end else begin
                sda_oe <= ~tx[7]; tx <= {tx[6:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda_s[1];
            else if (scl_fall) begin
              if (mack) begin
                st <= S_RD; cnt <= '0; sda_oe <= ~rdata[7]; tx <= {rdata[6:0], 1'b0};
              end else st <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: an idle target never holds the data line
  a_r1_idle_release: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !sda_oe);
  // R2: the pointer moves by exactly one after each written byte
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
    wr |=> (ptr == $past(ptr) + 8'd1));
endmodule

// File: rtl/xcvr_regstore.sv
module xcvr_regstore
  import xcvr_diag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              h_blk,
  input  logic [BYTE_W-1:0] h_ptr,
  input  logic              h_wr,
  input  logic [BYTE_W-1:0] h_wdata,
  input  logic              loc_we,
  input  logic              loc_blk,
  input  logic [BYTE_W-1:0] loc_page,
  input  logic [BYTE_W-1:0] loc_addr,
  input  logic [BYTE_W-1:0] loc_wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              mark_vld,
  output logic [HALF_W-1:0] mark_off
);
  logic [BYTE_W-1:0] mem [0:MEM_DEPTH-1];
  logic [BYTE_W-1:0] page_q, rd_raw, rd_page;
  logic              rd_zero, rd_is_page;
  logic              hw_pend;
  logic [IDX_W-1:0]  hw_idx;
  logic [BYTE_W-1:0] hw_data;
  map_t              hmap, lmap;
  logic              h_is_sel, l_is_sel, h_ok, l_go;

  initial begin
    for (int i = 0; i < MEM_DEPTH; i++) mem[i] = '0;
  end

  always_comb begin
    hmap     = map_addr(h_blk, h_ptr, page_q, 1'b1);
    lmap     = map_addr(loc_blk, loc_addr, loc_page, 1'b0);
    h_is_sel = h_blk && (h_ptr == PAGE_SEL_ADDR);
    l_is_sel = loc_blk && (loc_addr == PAGE_SEL_ADDR);
    h_ok     = hmap.hit && !h_is_sel &&
               ((hmap.idx[IDX_W-1:HALF_W] != RG_DIAG_P2) || p2_host_writable(h_ptr[HALF_W-1:0]));
    l_go     = loc_we && lmap.hit && !l_is_sel;
  end

  // single write port: local first, host byte waits one cycle if needed
  always_ff @(posedge clk) begin
    if (l_go)         mem[lmap.idx] <= loc_wdata;
    else if (hw_pend) mem[hw_idx]   <= hw_data;
    rd_raw <= mem[hmap.idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= PAGE_BASE; hw_pend <= 1'b0; hw_idx <= '0; hw_data <= '0;
      mark_vld <= 1'b0; mark_off <= '0;
      rd_zero <= 1'b1; rd_is_page <= 1'b0; rd_page <= '0;
    end else begin
      if (loc_we && l_is_sel)   page_q <= loc_wdata;
      else if (h_wr && h_is_sel) page_q <= h_wdata;
      if (h_wr && h_ok) begin
        hw_pend <= 1'b1; hw_idx <= hmap.idx; hw_data <= h_wdata;
      end else if (!l_go) hw_pend <= 1'b0;
      mark_vld   <= h_wr && h_ok && (hmap.idx[IDX_W-1:HALF_W] == RG_DIAG_P2);
      mark_off   <= h_ptr[HALF_W-1:0];
      rd_zero    <= !hmap.hit;
      rd_is_page <= h_is_sel;
      rd_page    <= page_q;
    end
  end

  assign rdata = rd_is_page ? rd_page : (rd_zero ? '0 : rd_raw);

  // R6: undefined parameter-page bytes read as zero
  a_r6_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (h_blk && h_ptr[7] && page_q == PAGE_PARAM && !p2_defined(h_ptr[HALF_W-1:0])) |=> (rdata == 8'h00));
  // R9: unimplemented page reads as zero
  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    (h_blk && h_ptr[7] && page_q != PAGE_BASE && page_q != PAGE_PARAM) |=> (rdata == 8'h00));
  // R8: a held host byte drains as soon as the local port is quiet
  a_r8_host_wr_drains: assert property (@(posedge clk) disable iff (rst)
    (hw_pend && !loc_we && !h_wr) |=> !hw_pend);
endmodule

// File: rtl/xcvr_notify.sv
module xcvr_notify
  import xcvr_diag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mark_vld,
  input  logic [HALF_W-1:0] mark_off,
  input  logic              stop_p,
  input  logic              bus_idle,
  output logic              note_vld,
  output logic [BYTE_W-1:0] note_page,
  output logic [BYTE_W-1:0] note_addr
);
  localparam int SLOTS = 1 << HALF_W;

  logic [SLOTS-1:0]  pend;
  logic              scan;
  logic [HALF_W-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0; scan <= 1'b0; pos <= '0;
      note_vld <= 1'b0; note_page <= '0; note_addr <= '0;
    end else begin
      note_vld <= 1'b0;
      if (stop_p) begin
        scan <= 1'b1; pos <= '0;
      end else if (scan && bus_idle) begin
        if (pend[pos]) begin
          note_vld  <= 1'b1;
          note_page <= PAGE_PARAM;
          note_addr <= {1'b1, pos};
        end
        pend[pos] <= 1'b0;
        pos <= pos + 1'b1;
        if (pos == HALF_W'(SLOTS - 1)) scan <= 1'b0;
      end
      if (mark_vld) pend[mark_off] <= 1'b1;
    end
  end

  // R10: back-to-back notifications name distinct bytes in rising order
  a_r10_ascending: assert property (@(posedge clk) disable iff (rst)
    note_vld |=> (!note_vld || note_addr > $past(note_addr)));
  // R10: notifications always point into the upper half of the parameter page
  a_r10_upper_half: assert property (@(posedge clk) disable iff (rst)
    note_vld |-> (note_addr[7] && note_page == PAGE_PARAM));
endmodule

// File: rtl/xcvr_diag_target.sv
module xcvr_diag_target
  import xcvr_diag_pkg::*;
#(
  parameter logic [6:0] INFO_DEV = 7'h50,
  parameter logic [6:0] DIAG_DEV = 7'h51
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       loc_we,
  input  logic       loc_blk,
  input  logic [7:0] loc_page,
  input  logic [7:0] loc_addr,
  input  logic [7:0] loc_wdata,
  output logic       note_vld,
  output logic [7:0] note_page,
  output logic [7:0] note_addr
);
  logic              h_blk, h_wr, stop_p, bus_idle, mark_vld;
  logic [BYTE_W-1:0] h_ptr, h_wdata, rdata;
  logic [HALF_W-1:0] mark_off;

  xcvr_i2c_link #(.INFO_DEV(INFO_DEV), .DIAG_DEV(DIAG_DEV)) u_link (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .blk(h_blk), .ptr(h_ptr), .wr(h_wr), .wdata(h_wdata), .rdata(rdata),
    .stop_p(stop_p), .idle(bus_idle)
  );

  xcvr_regstore u_store (
    .clk(clk), .rst(rst), .h_blk(h_blk), .h_ptr(h_ptr), .h_wr(h_wr), .h_wdata(h_wdata),
    .loc_we(loc_we), .loc_blk(loc_blk), .loc_page(loc_page), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .rdata(rdata), .mark_vld(mark_vld), .mark_off(mark_off)
  );

  xcvr_notify u_note (
    .clk(clk), .rst(rst), .mark_vld(mark_vld), .mark_off(mark_off), .stop_p(stop_p),
    .bus_idle(bus_idle), .note_vld(note_vld), .note_page(note_page), .note_addr(note_addr)
  );
endmodule

// File: tb/sim_xcvr_diag_target.sv
module sim_xcvr_diag_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam int GAP = 300;
  localparam logic [6:0] INFO = 7'h50;
  localparam logic [6:0] DIAG = 7'h51;

  logic clk = 1'b0, rst = 1'b1;
  logic m_scl = 1'b1, m_sda_low = 1'b0;
  logic sda_oe, note_vld;
  logic loc_we = 1'b0, loc_blk = 1'b0;
  logic [7:0] loc_page = '0, loc_addr = '0, loc_wdata = '0, note_page, note_addr;
  wire sda_line = ~(m_sda_low | sda_oe);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0]  exp_q[$], got_q[$];
  string       tag_q[$];
  logic [15:0] nexp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_diag_target u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .loc_we(loc_we), .loc_blk(loc_blk), .loc_page(loc_page), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .note_vld(note_vld), .note_page(note_page), .note_addr(note_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda_low = 1'b1; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda_low = 1'b0; tick(GAP);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    end
    m_sda_low = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); m_scl = 1'b0;
    end
    tick(Q); m_sda_low = give_ack; tick(Q); m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q); m_sda_low = 1'b0;
  endtask

  task automatic host_write(input logic [6:0] dev, input logic [7:0] ra,
                            input logic [31:0] d, input int n);
    bit ack;
    bus_start();
    send_byte({dev, 1'b0}, ack); check(ack, "R1 addr ack", 32'(ack), 1);
    send_byte(ra, ack);          check(ack, "R2 pointer ack", 32'(ack), 1);
    for (int i = n - 1; i >= 0; i--) begin
      send_byte(d[8*i +: 8], ack); check(ack, "R7 data ack", 32'(ack), 1);
    end
    bus_stop();
  endtask

  // driver: pushes expected bytes, the monitor compares what comes back
  task automatic host_read(input logic [6:0] dev, input logic [7:0] ra,
                           input int n, input logic [31:0] e, input string req);
    bit ack;
    logic [7:0] b;
    for (int i = n - 1; i >= 0; i--) begin
      exp_q.push_back(e[8*i +: 8]); tag_q.push_back(req);
    end
    bus_start();
    send_byte({dev, 1'b0}, ack); check(ack, "R1 addr ack", 32'(ack), 1);
    send_byte(ra, ack);          check(ack, "R2 pointer ack", 32'(ack), 1);
    bus_start();
    send_byte({dev, 1'b1}, ack); check(ack, "R1 read addr ack", 32'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      got_q.push_back(b);
    end
    bus_stop();
  endtask

  task automatic local_write(input logic blk, input logic [7:0] pg,
                             input logic [7:0] a, input logic [7:0] d);
    loc_blk = blk; loc_page = pg; loc_addr = a; loc_wdata = d; loc_we = 1'b1;
    tick(1);
    loc_we = 1'b0;
    tick(1);
  endtask

  // monitor for read data and notifications
  initial begin
    forever begin
      @(negedge clk);
      if (got_q.size() > 0) begin
        logic [7:0] g;
        g = got_q.pop_front();
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected read byte", 32'(g), 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(g == e, t, 32'(g), 32'(e));
        end
      end
      if (note_vld) begin
        if (nexp_q.size() == 0) check(1'b0, "R10 unexpected notify", {16'h0, note_page, note_addr}, 0);
        else begin
          logic [15:0] ne;
          ne = nexp_q.pop_front();
          check({note_page, note_addr} == ne, "R10 notify", {16'h0, note_page, note_addr}, 32'(ne));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    tick(10);
    rst = 1'b0;
    tick(2);
    check(!sda_oe, "R11 sda released after reset", 32'(sda_oe), 0);
    check(!note_vld, "R11 no notify after reset", 32'(note_vld), 0);
    host_read(DIAG, 8'h7F, 1, 32'h00, "R4 page select resets to 00");

    host_write(INFO, 8'h0A, 32'hAABBCC, 3);
    host_read(INFO, 8'h0A, 3, 32'hAABBCC, "R3 info storage burst");
    host_write(DIAG, 8'h0A, 32'h5A, 1);
    host_read(DIAG, 8'h0A, 1, 32'h5A, "R3 diag lower storage");
    host_read(INFO, 8'h0B, 1, 32'hBB, "R3 blocks kept apart");

    host_write(INFO, 8'hFF, 32'h1122, 2);
    host_read(INFO, 8'hFF, 2, 32'h1122, "R2 wrap 255 to 0");

    bus_start();
    send_byte({7'h52, 1'b0}, ack);
    check(!ack, "R1 foreign address not acked", 32'(ack), 0);
    bus_stop();

    host_write(DIAG, 8'hC8, 32'h77, 1);
    host_read(DIAG, 8'hC8, 1, 32'h77, "R4 page 0 storage");

    host_write(DIAG, 8'h7F, 32'h02, 1);
    host_read(DIAG, 8'h7F, 1, 32'h02, "R4 page select readback");
    host_read(DIAG, 8'hC8, 1, 32'h00, "R6 undefined byte on parameter page");

    for (int a = 8'h84; a <= 8'h87; a++) nexp_q.push_back({8'h02, 8'(a)});
    host_write(DIAG, 8'h84, 32'h12345678, 4);
    host_read(DIAG, 8'h84, 4, 32'h12345678, "R5 frequency and width big-endian");

    host_write(DIAG, 8'h8C, 32'hFF, 1);
    host_read(DIAG, 8'h8C, 1, 32'h00, "R7 RX power host write ignored");

    local_write(1'b1, 8'h02, 8'h8C, 8'h01);
    local_write(1'b1, 8'h02, 8'h8D, 8'h02);
    local_write(1'b1, 8'h02, 8'h8E, 8'h03);
    local_write(1'b1, 8'h02, 8'h8F, 8'h04);
    host_read(DIAG, 8'h8C, 4, 32'h01020304, "R8 local write of RX power");

    local_write(1'b1, 8'h02, 8'h94, 8'h0C);
    nexp_q.push_back({8'h02, 8'h95});
    host_write(DIAG, 8'h95, 32'h07, 1);
    host_read(DIAG, 8'h94, 2, 32'h0C07, "R5 BER and MCS bytes");

    host_write(DIAG, 8'h96, 32'h55, 1);
    host_read(DIAG, 8'h96, 1, 32'h00, "R6 undefined write discarded");

    host_write(DIAG, 8'h7F, 32'h05, 1);
    host_read(DIAG, 8'h80, 1, 32'h00, "R9 unimplemented page reads zero");
    host_write(DIAG, 8'hC8, 32'h99, 1);
    host_write(DIAG, 8'h7F, 32'h00, 1);
    host_read(DIAG, 8'hC8, 1, 32'h77, "R9 page 0 survives dropped write");

    tick(GAP);
    check(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
    check(nexp_q.size() == 0, "R10 all notifications seen", nexp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule